// File: doc/BRIEF.md
# Token-Ordered Completion Buffer

This block puts results that finish out of order back into the order in which their work was started. A requester first draws a token. The token reserves the next slot of a 16-entry circular store and is returned as a 4-bit index. The work then runs through some variable-latency path. When it finishes, a producer deposits the result along with that token. The buffer hands results out strictly in token order, so a finished younger result waits until every older one has been delivered.

Token issue and result delivery each use a valid/ready handshake. Deposits have no handshake and are always taken. Drawing a token, depositing a result and delivering a result can all happen in the same clock cycle. The store therefore has two slot-write paths, one that clears a slot on issue and one that fills a slot on deposit, plus one read path at the head. A single occupancy counter absorbs an increment and a decrement in the same cycle. Tokens that are invalid or used twice are the caller's responsibility.

Top module: `cmpl_order_buf`

## Requirements
- R1: After a synchronous active-high reset, `tok_valid` is 1, `tok_id` is 0 and `res_valid` is 0.
- R2: Tokens are issued as consecutive indices 0, 1, …, 15 and then wrap back to 0. `tok_id` is the index handed out when `tok_valid && tok_ready` is sampled at a rising edge.
- R3: `tok_valid` is 1 exactly when fewer than 16 tokens are outstanding. A token counts as outstanding from its issue until its result is delivered.
- R4: A deposit (`put_en` high) stores `put_data` in the slot named by `put_tok` and marks that slot filled. Slots may be filled in any order.
- R5: `res_valid` is 1 only when at least one token is outstanding and the slot of the oldest outstanding token is filled. Filled younger slots do not raise it.
- R6: Each result is delivered once when `res_valid && res_ready` at a rising edge, in token issue order, and the head index wraps from 15 to 0.
- R7: When a token is issued and a result is delivered in the same cycle, the outstanding count does not change.
- R8: Token issue, deposit and delivery in a single cycle all take effect.
- R9: A deposit to the oldest outstanding token raises `res_valid` in the following cycle.
- R10: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tok_valid | output | 1 | A token is available |
| tok_ready | input | 1 | Requester takes the offered token |
| tok_id | output | 4 | Token being offered |
| put_en | input | 1 | Deposit a result |
| put_tok | input | 4 | Token of the deposited result |
| put_data | input | DATA_W (32) | Deposited result |
| res_valid | output | 1 | Oldest result is ready |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | DATA_W (32) | Oldest result |

## Verification
The hardest case to reach is the one where the buffer holds many filled younger slots while the oldest slot is still empty, and then token issue, a deposit and a delivery all land in the same cycle. The directed stimulus fills all 16 tokens and deposits them in reverse order, so delivery stays held until the very last deposit. A long pseudo-random phase then picks, in each cycle and independently, whether to draw a token, whether to deposit and which outstanding token to deposit, and whether to accept a result. That produces triple-operation cycles and wraps of both indices. A final directed step brings the buffer to 15 outstanding tokens and issues and delivers in the same cycle, which shows that the count was held.

// File: rtl/cob_pkg.sv
package cob_pkg;
  // Operations that fire on one clock edge
  typedef struct packed {
    logic issue;
    logic deposit;
    logic deliver;
  } cob_ops_t;
endpackage

// File: rtl/cob_wrap_ptr.sv
module cob_wrap_ptr #(
  parameter int SLOTS = 16,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(SLOTS - 1);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst)      ptr_q <= '0;
    else if (adv) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr = ptr_q;

  // R2 / R6: an advance from the last index returns to zero
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && ptr_q == LAST) |=> (ptr_q == '0));

  // R2 / R6: without an advance the index holds
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr_q));
endmodule

// File: rtl/cob_occupancy.sv
module cob_occupancy #(
  parameter int SLOTS = 16,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          not_full,
  output logic          not_empty
);
  localparam logic [CW-1:0] CAP = CW'(SLOTS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          nf_q, ne_q;

  // One adder path, increment and decrement merged (R7)
  always_comb begin
    unique case ({inc, dec})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      nf_q  <= 1'b1;
      ne_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      nf_q  <= (cnt_d != CAP);
      ne_q  <= (cnt_d != '0);
    end
  end

  assign count     = cnt_q;
  assign not_full  = nf_q;
  assign not_empty = ne_q;

  a_r3_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CAP);

  a_r3_full_flag: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CAP) |-> !nf_q);

  a_r7_merge_hold: assert property (@(posedge clk) disable iff (rst)
    (inc && dec) |=> $stable(cnt_q));

  a_r6_dec_step: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cob_slot_store.sv
module cob_slot_store #(
  parameter int SLOTS  = 16,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_en,
  input  logic [AW-1:0]     clr_idx,
  input  logic              set_en,
  input  logic [AW-1:0]     set_idx,
  input  logic [DATA_W-1:0] set_data,
  input  logic [AW-1:0]     rd_idx,
  output logic              rd_filled,
  output logic [DATA_W-1:0] rd_data
);
  logic [SLOTS-1:0]  filled_q;
  logic [DATA_W-1:0] mem [SLOTS];

  // Per-slot filled flag: clear on issue, set on deposit
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                  filled_q[g] <= 1'b0;
      else if (clr_en && clr_idx == AW'(g))     filled_q[g] <= 1'b0;
      else if (set_en && set_idx == AW'(g))     filled_q[g] <= 1'b1;
    end
  end

  // Payload array: single write port, no reset, RAM-inferable
  always_ff @(posedge clk) begin
    if (set_en) mem[set_idx] <= set_data;
  end

  assign rd_filled = filled_q[rd_idx];
  assign rd_data   = mem[rd_idx];

  // R4: a deposit to a slot not being cleared leaves it filled
  a_r4_fill: assert property (@(posedge clk) disable iff (rst)
    (set_en && !(clr_en && clr_idx == set_idx)) |=> filled_q[$past(set_idx)]);

  // R4: the payload read back matches the last deposit to that slot
  a_r4_payload: assert property (@(posedge clk) disable iff (rst)
    (set_en && rd_idx == set_idx) |=> (rd_data == $past(set_data) || rd_idx != $past(rd_idx)));
endmodule

// File: rtl/cmpl_order_buf.sv
module cmpl_order_buf #(
  parameter int SLOTS  = 16,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(SLOTS),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              tok_valid,
  input  logic              tok_ready,
  output logic [AW-1:0]     tok_id,
  input  logic              put_en,
  input  logic [AW-1:0]     put_tok,
  input  logic [DATA_W-1:0] put_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data
);
  import cob_pkg::*;

  logic [AW-1:0] in_ptr, out_ptr;
  logic [CW-1:0] count;
  logic          not_full, not_empty;
  logic          head_filled;
  cob_ops_t      ops;

  assign ops.issue   = not_full & tok_ready;
  assign ops.deposit = put_en;
  assign ops.deliver = res_valid & res_ready;

  cob_wrap_ptr #(.SLOTS(SLOTS)) u_in_ptr (
    .clk(clk), .rst(rst), .adv(ops.issue), .ptr(in_ptr)
  );

  cob_wrap_ptr #(.SLOTS(SLOTS)) u_out_ptr (
    .clk(clk), .rst(rst), .adv(ops.deliver), .ptr(out_ptr)
  );

  cob_occupancy #(.SLOTS(SLOTS)) u_occ (
    .clk(clk), .rst(rst), .inc(ops.issue), .dec(ops.deliver),
    .count(count), .not_full(not_full), .not_empty(not_empty)
  );

  cob_slot_store #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .clr_en(ops.issue), .clr_idx(in_ptr),
    .set_en(ops.deposit), .set_idx(put_tok), .set_data(put_data),
    .rd_idx(out_ptr), .rd_filled(head_filled), .rd_data(res_data)
  );

  assign tok_valid = not_full;
  assign tok_id    = in_ptr;
  assign res_valid = not_empty & head_filled;

  // R5: nothing is offered while no token is outstanding
  a_r5_empty_quiet: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> !res_valid);

  // R10: an offered result waits unchanged for the consumer
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R9: a deposit into the empty head slot shows up next cycle
  a_r9_head_fill: assert property (@(posedge clk) disable iff (rst)
    (put_en && put_tok == out_ptr && count != '0 && !res_valid) |=> res_valid);

  // R3: issue never happens with all slots outstanding
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(SLOTS)) |-> !tok_valid);
endmodule

// File: tb/cmpl_order_buf_tb_top.sv
module cmpl_order_buf_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tok_valid, tok_ready = 1'b0;
  logic [3:0]    tok_id;
  logic          put_en = 1'b0;
  logic [3:0]    put_tok = '0;
  logic [DW-1:0] put_data = '0;
  logic          res_valid, res_ready = 1'b0;
  logic [DW-1:0] res_data;

  always #4 clk = ~clk;   // 125 MHz

  cmpl_order_buf #(.SLOTS(16), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst),
    .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_id(tok_id),
    .put_en(put_en), .put_tok(put_tok), .put_data(put_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  int checks = 0, errors = 0;
  bit running = 0, done = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference state, derived from the requirements
  int            mcount = 0;
  logic [3:0]    mnext = '0, mhead = '0;
  bit [15:0]     filled = '0, waiting = '0;
  logic [DW-1:0] data_of [16];
  logic [DW-1:0] expq [$];
  bit            prev_hold = 0;
  logic [DW-1:0] prev_data = '0;
  int            triple = 0;
  logic [31:0]   seed = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  // Monitor / scoreboard: samples 2 ns after the falling edge
  always @(negedge clk) begin
    #2;
    if (running) begin
      bit f_tok, f_res, exp_rv;
      f_tok  = tok_valid && tok_ready;
      f_res  = res_valid && res_ready;
      exp_rv = (mcount > 0) && filled[mhead];
      chk(tok_valid == (mcount < 16), "R3 tok_valid", tok_valid, mcount < 16);
      chk(res_valid == exp_rv, "R5 res_valid", res_valid, exp_rv);
      if (prev_hold) chk(res_valid && res_data == prev_data, "R10 hold", res_data, prev_data);
      if (f_tok) begin
        logic [DW-1:0] d;
        chk(tok_id == mnext, "R2 token order", tok_id, mnext);
        d = rnd();
        data_of[tok_id] = d;
        expq.push_back(d);
        waiting[tok_id] = 1'b1;
        mnext++;
      end
      if (f_res) begin
        logic [DW-1:0] e;
        e = (expq.size() > 0) ? expq.pop_front() : '0;
        chk(res_data == e, "R6 result order", res_data, e);
        mhead++;
      end
      if (f_tok && f_res && put_en) triple++;
      if (put_en) begin
        filled[put_tok]  = 1'b1;   // R4
        waiting[put_tok] = 1'b0;
      end
      if (f_tok) filled[tok_id] = 1'b0;
      mcount += int'(f_tok) - int'(f_res);   // R7: both cancel
      prev_hold = res_valid && !res_ready;
      prev_data = res_data;
    end
  end

  task automatic step(); @(negedge clk); endtask

  // Deposit one outstanding token chosen at random, if any
  task automatic put_any();
    logic [3:0] s;
    s = rnd();
    put_en = 1'b0;
    for (int k = 0; k < 16; k++) begin
      logic [3:0] t;
      t = s + 4'(k);
      if (waiting[t] && !put_en) begin
        put_en = 1'b1; put_tok = t; put_data = data_of[t];
      end
    end
  endtask

  task automatic drain();
    tok_ready = 0; res_ready = 1;
    for (int n = 0; n < 200 && mcount > 0; n++) begin
      put_any();
      step();
    end
    put_en = 0;
  endtask

  initial begin
    repeat (3) step();
    rst = 0;
    #1;
    chk(tok_valid == 1, "R1 tok_valid", tok_valid, 1);
    chk(tok_id == 0, "R1 tok_id", tok_id, 0);
    chk(res_valid == 0, "R1 res_valid", res_valid, 0);
    running = 1;

    // Fill every slot, one extra request must stall
    tok_ready = 1; res_ready = 1;
    repeat (17) step();
    tok_ready = 0;
    chk(tok_valid == 0, "R3 full", tok_valid, 0);
    // Deposit youngest first: delivery must stay held
    for (int t = 15; t >= 1; t--) begin
      put_en = 1; put_tok = 4'(t); put_data = data_of[t];
      step();
    end
    put_en = 0;
    step(); #1;
    chk(res_valid == 0, "R5 head empty", res_valid, 0);
    put_en = 1; put_tok = 0; put_data = data_of[0]; res_ready = 0;
    step(); put_en = 0; #1;
    chk(res_valid == 1, "R9 head filled", res_valid, 1);
    step(); step();   // R10 hold observed by the monitor
    drain();

    // Mixed traffic, all three operations overlapping
    for (int c = 0; c < 3000; c++) begin
      logic [31:0] r;
      r = rnd();
      tok_ready = r[0] | r[1];
      res_ready = r[2] | r[3];
      if (r[4] | r[5]) put_any(); else put_en = 0;
      step();
    end
    put_en = 0;
    drain();
    chk(triple > 0, "R8 triple cycles", triple, 1);
    chk(expq.size() == 0, "R6 all delivered", expq.size(), 0);

    // 15 outstanding, then issue and deliver together
    tok_ready = 1; res_ready = 0;
    repeat (15) step();
    tok_ready = 0;
    put_en = 1; put_tok = mhead; put_data = data_of[mhead];
    step(); put_en = 0;
    tok_ready = 1; res_ready = 1;
    step(); #1;
    tok_ready = 0; res_ready = 0;
    chk(tok_valid == 1, "R7 count held at 15", tok_valid, 1);
    tok_ready = 1;
    step(); #1;
    tok_ready = 0;
    chk(tok_valid == 0, "R7 now full", tok_valid, 0);
    drain();
    step(); step();

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule